// File: doc/BRIEF.md
# Quasi-Bidirectional Port Expander with Two-Wire Serial Slave

This block is a two-wire serial (I2C) slave that owns one 8-bit quasi-bidirectional port. The bus address is a fixed four-bit prefix, then three strap inputs, then the read/write flag. A write transfer carries one or more data bytes. Each byte is acknowledged and then copied into the port latch. A read transfer returns a fresh sample of the port pins for every byte, for as long as the master keeps acknowledging.

The port has no direction register. A latch bit of 0 pulls its pin low. A latch bit of 1 leaves the pin at a weak high, so an outside driver can pull it low and the pin can serve as an input. Every bit written as 1 also raises a strong pull-up strobe for that pin. The strobe stays up until the next falling edge of the clock line.

Both bus lines are sampled on the system clock. They pass through a synchroniser and a spike filter before start, stop and edge detection. The data line is open-drain: the block only ever drives it low.

Top module: `qbp_expander`

## Requirements
- R1: The slave answers only to the address byte {0,1,0,0, strap[2], strap[1], strap[0], rw}, sent MSB first, where rw=1 means read and rw=0 means write. It acknowledges by holding SDA low during the ninth clock of the address byte.
- R2: After reset the port latch is 8'hFF, every pull-up strobe is 0, and SDA is not driven.
- R3: In a write transfer every data byte is acknowledged and loaded into the port latch after the SCL falling edge that closes its acknowledge slot. Several bytes in one transfer each update the latch in turn, and the latch changes at no other time.
- R4: In a read transfer each byte is a sample of the pin levels taken at the SCL falling edge that opens that byte, sent MSB first. A new sample is taken for every byte the master acknowledges.
- R5: For every bit loaded as 1, the pull-up strobe of that pin is 1 from the load until the next SCL falling edge. Bits loaded as 0 never raise their strobe.
- R6: A latch bit of 0 forces its pin low. A pin therefore reads back as the latch value ANDed with the external level.
- R7: START (SDA falling while SCL is high), repeated START and STOP (SDA rising while SCL is high) are recognised at any point. The slave changes its SDA drive only while SCL is low.
- R8: A master not-acknowledge after a read byte ends the read. The slave then releases SDA and drives nothing until the next START.
- R9: A low or high pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored.
- R10: When the address byte does not match, the slave does not drive SDA, leaves the latch unchanged and ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Level seen on the serial clock line |
| sda_in | input | 1 | Level seen on the serial data line |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_addr | input | 3 | Strap pins forming the low three address bits |
| pin_level | input | 8 | Actual level of each port pin |
| port_latch | output | 8 | Per pin: 1 means weak high, 0 means driven low |
| pullup_strobe | output | 8 | Per pin strong pull-up enable |

## Verification
The hardest situation to reach from the ports is a spike on a bus line in the middle of a byte. Such a spike would insert a false clock edge or a false START if the filter let it through. The bench produces it with a dedicated byte-send task. While SCL is high, that task pulls SCL low for two system clocks on one bit. On another bit it pulls SDA low for two system clocks. The latch must still end up holding the intended byte. The pull-up strobe lifetime is also awkward to reach, because the falling edge that ends it only arrives with the next transfer. The bench therefore checks the strobe after a STOP, and checks it again after the following START.

// File: rtl/qbp_pkg.sv
// Package: shared constants and the bus slave state type.
// Assumes a byte-wide serial protocol with a 7-bit address plus direction flag.
package qbp_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [3:0] DEV_PREFIX = 4'b0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } qbp_state_t;
endpackage

// File: rtl/qbp_deglitch.sv
// Module: two-flop synchroniser followed by a persistence filter for one bus line.
// The output follows the input only after the synchronised input has differed
// from it for FILT_LEN consecutive clocks. Assumes FILT_LEN >= 1.
module qbp_deglitch #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int FC_W = $clog2(FILT_LEN + 1);

    logic            s1, s2;
    logic [FC_W-1:0] run_cnt;

    // Synchronise, then count consecutive disagreeing clocks before accepting a level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            clean   <= 1'b1;
            run_cnt <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 != clean) begin
                if (run_cnt == FC_W'(FILT_LEN - 1)) begin
                    clean   <= s2;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    AST_FILTER_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(clean) |-> (clean == $past(s2)));  // R9
endmodule

// File: rtl/qbp_bus_slave.sv
// Module: serial bus slave engine. It detects START, STOP and clock edges on the
// filtered lines, matches the address, receives write bytes and sends pin samples.
// Assumes the filtered lines idle high and the master keeps at least a few system
// clocks between edges.
module qbp_bus_slave
    import qbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] pin_sample,
    output logic              sda_low,
    output logic              port_load,
    output logic [BYTE_W-1:0] port_data,
    output logic              scl_fall
);
    logic              scl_q, sda_q;
    logic              scl_rise, start_cond, stop_cond;
    qbp_state_t        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic              rw_flag, master_ack;

    // Hold the previous filtered levels so edges and bus conditions can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise   = scl_f & ~scl_q;
    assign scl_fall   = ~scl_f & scl_q;
    assign start_cond = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_cond  = scl_f & scl_q & ~sda_q & sda_f;

    // Protocol sequencer: address, acknowledge, write data and read data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rw_flag    <= 1'b0;
            master_ack <= 1'b0;
            sda_low    <= 1'b0;
            port_load  <= 1'b0;
            port_data  <= '1;
        end else begin
            port_load <= 1'b0;
            if (start_cond) begin
                state   <= ST_ADDR;
                bitcnt  <= '0;
                sda_low <= 1'b0;
            end else if (stop_cond) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
                            if (state == ST_ADDR) begin
                                if (rx_sh[BYTE_W-1:1] == {DEV_PREFIX, strap}) begin
                                    state   <= ST_ADDR_ACK;
                                    sda_low <= 1'b1;
                                    rw_flag <= rx_sh[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state     <= ST_WR_ACK;
                                sda_low   <= 1'b1;
                                port_data <= rx_sh;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw_flag) begin
                                state   <= ST_RD_DATA;
                                tx_sh   <= pin_sample;
                                sda_low <= ~pin_sample[BYTE_W-1];
                            end else begin
                                state   <= ST_WR_DATA;
                                sda_low <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            port_load <= 1'b1;
                            state     <= ST_WR_DATA;
                            sda_low   <= 1'b0;
                            bitcnt    <= '0;
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_fall) begin
                            if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                                state   <= ST_RD_ACK;
                                sda_low <= 1'b0;
                                bitcnt  <= '0;
                            end else begin
                                bitcnt  <= bitcnt + 1'b1;
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_low <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_f;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                state   <= ST_RD_DATA;
                                tx_sh   <= pin_sample;
                                sda_low <= ~pin_sample[BYTE_W-1];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !$past(scl_f));  // R7
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_low);  // R10
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_W'(BYTE_W));  // R3
endmodule

// File: rtl/qbp_port.sv
// Module: port latch, strong pull-up strobes and input synchroniser.
// Assumes load pulses last one clock and never coincide with an SCL falling edge.
module qbp_port #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PORT_W-1:0] load_data,
    input  logic              scl_fall,
    input  logic [PORT_W-1:0] pin_level,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] pullup_q,
    output logic [PORT_W-1:0] pin_sample
);
    logic [PORT_W-1:0] sync_q [SYNC_STAGES];

    // Latch update and pull-up pulse: raised by a load, dropped at the next SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q  <= '1;
            pullup_q <= '0;
        end else if (load) begin
            latch_q  <= load_data;
            pullup_q <= load_data;
        end else if (scl_fall) begin
            pullup_q <= '0;
        end
    end

    // Input synchroniser chain for the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
        end else begin
            sync_q[0] <= pin_level;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign pin_sample = sync_q[SYNC_STAGES-1];

    AST_LATCH_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(latch_q) |-> $past(load));  // R3
    AST_PULLUP_WITHIN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_q & ~latch_q) == '0);  // R5
    AST_PULLUP_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !load) |=> (pullup_q == '0));  // R5
endmodule

// File: rtl/qbp_expander.sv
// Module: top level of the quasi-bidirectional port expander.
// It filters both bus lines, runs the slave engine and owns the port state.
// Assumes the bus levels arrive asynchronously and the data line is open-drain.
module qbp_expander #(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    input  logic [2:0] strap_addr,
    input  logic [7:0] pin_level,
    output logic [7:0] port_latch,
    output logic [7:0] pullup_strobe
);
    import qbp_pkg::*;

    logic [1:0]        raw_lines, clean_lines;
    logic              scl_fall, port_load;
    logic [BYTE_W-1:0] port_data, pin_sample;

    assign raw_lines = {sda_in, scl_in};

    // One filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_line
        qbp_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    qbp_bus_slave u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (clean_lines[0]),
        .sda_f      (clean_lines[1]),
        .strap      (strap_addr),
        .pin_sample (pin_sample),
        .sda_low    (sda_drive_low),
        .port_load  (port_load),
        .port_data  (port_data),
        .scl_fall   (scl_fall)
    );

    qbp_port #(.PORT_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (port_load),
        .load_data  (port_data),
        .scl_fall   (scl_fall),
        .pin_level  (pin_level),
        .latch_q    (port_latch),
        .pullup_q   (pullup_strobe),
        .pin_sample (pin_sample)
    );
endmodule

// File: tb/qbp_expander_test.sv
// Bench: a bus master model, a vector table of write/read pairs, then directed tests.
module qbp_expander_test;
    localparam int Q = 20;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] ADDR_W = {4'b0100, STRAP, 1'b0};
    localparam logic [7:0] ADDR_R = {4'b0100, STRAP, 1'b1};

    // Each entry: {byte written to the latch, external pin levels for the read}
    localparam logic [15:0] VEC [6] = '{
        {8'h00, 8'hFF}, {8'hFF, 8'hA5}, {8'h0F, 8'hFF},
        {8'hF0, 8'h3C}, {8'hFF, 8'hFF}, {8'h81, 8'h7E}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [7:0] ext_pins = 8'hFF;
    logic       sda_drive_low;
    logic [7:0] port_latch, pullup_strobe;
    logic       sda_line;
    logic [7:0] pin_level;
    int         checks = 0, errors = 0;
    logic       mon_en = 1'b0;
    int         drive_seen = 0;

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_drive_low;
    assign pin_level = port_latch & ext_pins;  // R6: latch 0 forces the pin low

    qbp_expander uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .strap_addr    (STRAP),
        .pin_level     (pin_level),
        .port_latch    (port_latch),
        .pullup_strobe (pullup_strobe)
    );

    always @(negedge clk) if (mon_en && sda_drive_low) drive_seen++;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
        s = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    // Same as send_byte, with a short SCL low spike on bit 5 and an SDA low spike on bit 2.
    task automatic send_byte_spiky(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_sda = d[i]; tick(Q); m_scl = 1'b1; tick(Q);
            if (i == 5) begin m_scl = 1'b0; tick(2); m_scl = 1'b1; end
            if (i == 2) begin m_sda = 1'b0; tick(2); m_sda = d[i]; end
            tick(Q); m_scl = 1'b0; tick(Q);
        end
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic nack, input logic [7:0] next_ext, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, s); d[i] = s; end
        ext_pins = next_ext;
        bit_xfer(nack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        tick(5); rst_n = 1'b1; tick(5);
        chk("R2 latch reset", port_latch, 8'hFF);
        chk("R2 pullup reset", pullup_strobe, 8'h00);
        chk("R2 sda released", {7'd0, sda_drive_low}, 8'h00);

        // Table walk: write a latch value, then read the pins back.
        for (int v = 0; v < 6; v++) begin
            logic [7:0] wv, ev;
            wv = VEC[v][15:8]; ev = VEC[v][7:0];
            bus_start();
            send_byte(ADDR_W, ack); chk("R1 address ack", {7'd0, ack}, 8'h01);
            send_byte(wv, ack);     chk("R3 data ack", {7'd0, ack}, 8'h01);
            bus_stop();
            chk("R3 latch value", port_latch, wv);
            ext_pins = ev;
            bus_start();
            send_byte(ADDR_R, ack); chk("R1 read address ack", {7'd0, ack}, 8'h01);
            recv_byte(1'b1, ev, rd);
            chk("R6 read equals latch AND pins", rd, wv & ev);
            bus_stop();
        end

        // R3: several bytes in one write transfer, each reaching the latch in turn.
        ext_pins = 8'hFF;
        bus_start();
        send_byte(ADDR_W, ack);
        send_byte(8'h11, ack); chk("R3 multi byte 1", port_latch, 8'h11);
        send_byte(8'h22, ack); chk("R3 multi byte 2", port_latch, 8'h22);
        send_byte(8'h33, ack); chk("R3 multi byte 3", port_latch, 8'h33);
        bus_stop();

        // R5: the strobe holds the written ones until the next SCL fall.
        bus_start(); send_byte(ADDR_W, ack); send_byte(8'h3C, ack); bus_stop();
        chk("R5 pullup after write", pullup_strobe, 8'h3C);
        bus_start();
        chk("R5 pullup cleared by SCL fall", pullup_strobe, 8'h00);
        bus_stop();

        // R4/R8: sequential read with a fresh sample per byte, then NACK ends it.
        bus_start(); send_byte(ADDR_W, ack); send_byte(8'hFF, ack); bus_stop();
        ext_pins = 8'h5A;
        bus_start(); send_byte(ADDR_R, ack);
        recv_byte(1'b0, 8'hC3, rd); chk("R4 first sample", rd, 8'h5A);
        recv_byte(1'b1, 8'h00, rd); chk("R4 second sample", rd, 8'hC3);
        recv_byte(1'b1, 8'h00, rd); chk("R8 released after nack", rd, 8'hFF);
        bus_stop();

        // R7: a repeated START switches a write transfer into a read.
        ext_pins = 8'hFF;
        bus_start(); send_byte(ADDR_W, ack); send_byte(8'h77, ack);
        bus_start(); send_byte(ADDR_R, ack);
        chk("R7 repeated start ack", {7'd0, ack}, 8'h01);
        recv_byte(1'b1, 8'hFF, rd); chk("R7 read after repeated start", rd, 8'h77);
        bus_stop();

        // R10: wrong strap bits and a foreign prefix get no response.
        bus_start(); send_byte(ADDR_W, ack); send_byte(8'hFF, ack); bus_stop();
        mon_en = 1'b1;
        bus_start();
        send_byte({4'b0100, 3'b100, 1'b0}, ack); chk("R10 wrong strap no ack", {7'd0, ack}, 8'h00);
        send_byte(8'h00, ack); chk("R10 data ignored no ack", {7'd0, ack}, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ack); chk("R10 wrong prefix no ack", {7'd0, ack}, 8'h00);
        send_byte(8'h00, ack);
        bus_stop();
        mon_en = 1'b0;
        chk("R10 latch unchanged", port_latch, 8'hFF);
        chk("R10 sda never driven", 8'(drive_seen), 8'h00);

        // R9: short spikes on both lines inside a data byte are ignored.
        bus_start(); send_byte(ADDR_W, ack);
        send_byte_spiky(8'hA5, ack);
        chk("R9 spiky byte acked", {7'd0, ack}, 8'h01);
        bus_stop();
        chk("R9 latch after spikes", port_latch, 8'hA5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule